// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block collects every interrupt condition of a UART and presents the single most urgent one as an 8-bit read-only identification byte, together with an active-high interrupt line. Software reads the byte to find out which service routine to run. Bit 0 is an active-low "pending" flag. Bits 5:0 carry a source code. Bits 7:6 show whether the FIFOs are in use.

Line status, receive-data-ready, receive-timeout and modem-change conditions arrive as level flags, which the neighbouring logic clears. The block keeps its own pending state for three sources. The transmit-holding-empty flag is set by a pulse and cleared by a holding-register write or by reading the byte while it is reported. The Xoff/special-character flag is set by a detect pulse and held until an Xon pulse. The CTS/RTS change flag is set by a pulse and cleared by reading the byte while it is reported.

All inputs, including the enables, are sampled into registers on each clock. The identification byte is a combinational function of those registers, so it reflects the inputs one cycle after they are sampled.

Top module: `uart_irq_id`

## Requirements
- R1: While reset is asserted and after its release with all inputs low, `isr_o` reads 0x01 and `irq_o` is 0.
- R2: The low six bits of `isr_o` identify the reported source with these codes: line status 0x06, receive timeout 0x0C, receive data ready 0x04, transmit holding empty 0x02, modem status change 0x00, Xoff/special character 0x10, CTS/RTS change 0x20, nothing pending 0x01.
- R3: When several enabled sources are pending, the one reported is the highest in this order: line status, receive timeout, receive data ready, transmit empty, modem change, Xoff, CTS/RTS change.
- R4: `irq_o` is 1 exactly when bit 0 of `isr_o` is 0.
- R5: A source is reported only when its bit in `src_en_i` is 1. Bit 0 enables receive data ready and receive timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem change, bit 4 Xoff, and bit 5 CTS/RTS change.
- R6: The Xoff and CTS/RTS sources are reported only while `enh_en_i` is 1; otherwise bits 5:4 of `isr_o` read 0.
- R7: An Xoff detect pulse sets the Xoff flag, which stays set until an Xon pulse. A detect and an Xon in the same cycle leave the flag set.
- R8: A transmit-empty pulse sets the transmit-empty flag. The flag clears on a holding-register write, or on a status read in a cycle where code 0x02 is being reported. A read while another source is reported leaves it set, and a new set pulse wins over a clear in the same cycle.
- R9: A CTS/RTS change pulse sets its flag. The flag clears only on a status read in a cycle where code 0x20 is being reported.
- R10: Bits 7:6 of `isr_o` both equal the sampled `fifo_en_i`.
- R11: `isr_o` and `irq_o` reflect the inputs sampled at the previous rising clock edge; a change of an input does not alter the outputs before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lsr_err_i | input | 1 | Line status error condition (level) |
| rx_rdy_i | input | 1 | Receive data ready condition (level) |
| rx_tmo_i | input | 1 | Receive timeout condition (level) |
| thr_empty_set_i | input | 1 | Transmit holding register became empty (pulse) |
| thr_write_i | input | 1 | Transmit holding register written (pulse) |
| msr_chg_i | input | 1 | Modem status change condition (level) |
| xoff_det_i | input | 1 | Xoff or special character detected (pulse) |
| xon_det_i | input | 1 | Xon character received (pulse) |
| flow_chg_i | input | 1 | CTS/RTS state change (pulse) |
| isr_rd_i | input | 1 | Identification byte read strobe |
| src_en_i | input | 6 | Per-source interrupt enables |
| enh_en_i | input | 1 | Enhanced-feature enable |
| fifo_en_i | input | 1 | FIFO enable |
| isr_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Each source is first driven alone, so that all seven codes and the idle value are seen and any code swap shows up. The sources are then turned on together and removed one by one from the top, which separates a correct priority chain from a reordered one. This includes the timeout versus data-ready tie within level two.

Directed sequences cover the held flags. They include reads while a different source is reported, set and clear pulses in the same cycle, an Xoff held over many cycles, and toggling of the enables and the enhanced bit while flags are pending; these expose wrong clear conditions and missing masks. A long run with random inputs, checked each cycle against the reference model, catches interactions that the directed cases miss.

// File: rtl/uart_irq_id_pkg.sv
package uart_irq_id_pkg;

  localparam int SRC_EN_W = 6;
  localparam int NUM_SRC  = 7;
  localparam int ID_W     = 6;
  localparam int ISR_W    = 8;

  // enable bit positions in src_en_i
  localparam int EN_RX   = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LSR  = 2;
  localparam int EN_MSR  = 3;
  localparam int EN_XOFF = 4;
  localparam int EN_FLOW = 5;

  // request index = priority rank, 0 is highest
  localparam int P_LSR   = 0;
  localparam int P_RXTO  = 1;
  localparam int P_RXRDY = 2;
  localparam int P_THR   = 3;
  localparam int P_MSR   = 4;
  localparam int P_XOFF  = 5;
  localparam int P_FLOW  = 6;

  localparam logic [ID_W-1:0] ID_NONE  = 6'h01;
  localparam logic [ID_W-1:0] ID_LSR   = 6'h06;
  localparam logic [ID_W-1:0] ID_RXTO  = 6'h0C;
  localparam logic [ID_W-1:0] ID_RXRDY = 6'h04;
  localparam logic [ID_W-1:0] ID_THR   = 6'h02;
  localparam logic [ID_W-1:0] ID_MSR   = 6'h00;
  localparam logic [ID_W-1:0] ID_XOFF  = 6'h10;
  localparam logic [ID_W-1:0] ID_FLOW  = 6'h20;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_LSR, SRC_RXTO, SRC_RXRDY, SRC_THR, SRC_MSR, SRC_XOFF, SRC_FLOW
  } irq_src_e;

  typedef struct packed {
    logic lsr;
    logic rxto;
    logic rxrdy;
    logic thr;
    logic msr;
    logic xoff;
    logic flow;
  } irq_flags_t;

  function automatic logic [ID_W-1:0] src_code(irq_src_e s);
    case (s)
      SRC_LSR:   return ID_LSR;
      SRC_RXTO:  return ID_RXTO;
      SRC_RXRDY: return ID_RXRDY;
      SRC_THR:   return ID_THR;
      SRC_MSR:   return ID_MSR;
      SRC_XOFF:  return ID_XOFF;
      SRC_FLOW:  return ID_FLOW;
      default:   return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_src_regs.sv
module uart_irq_src_regs
  import uart_irq_id_pkg::*;
#(
  parameter int EN_W = SRC_EN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lsr_err_i,
  input  logic            rx_rdy_i,
  input  logic            rx_tmo_i,
  input  logic            thr_set_i,
  input  logic            thr_wr_i,
  input  logic            msr_chg_i,
  input  logic            xoff_det_i,
  input  logic            xon_det_i,
  input  logic            flow_chg_i,
  input  logic            rd_thr_clr_i,
  input  logic            rd_flow_clr_i,
  input  logic [EN_W-1:0] src_en_i,
  input  logic            enh_en_i,
  input  logic            fifo_en_i,
  output irq_flags_t      flags_q,
  output logic [EN_W-1:0] en_q,
  output logic            enh_q,
  output logic            fifo_q
);

  irq_flags_t flags_d;

  always_comb begin
    flags_d       = flags_q;
    flags_d.lsr   = lsr_err_i;
    flags_d.rxto  = rx_tmo_i;
    flags_d.rxrdy = rx_rdy_i;
    flags_d.msr   = msr_chg_i;
    flags_d.thr   = thr_set_i  | (flags_q.thr  & ~(thr_wr_i | rd_thr_clr_i));
    flags_d.xoff  = xoff_det_i | (flags_q.xoff & ~xon_det_i);
    flags_d.flow  = flow_chg_i | (flags_q.flow & ~rd_flow_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      enh_q   <= 1'b0;
      fifo_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= src_en_i;
      enh_q   <= enh_en_i;
      fifo_q  <= fifo_en_i;
    end
  end

  AST_XOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.xoff && !xon_det_i) |=> flags_q.xoff); // R7
  AST_XON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_det_i && !xoff_det_i) |=> !flags_q.xoff); // R7
  AST_THR_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !thr_set_i) |=> !flags_q.thr); // R8
  AST_FLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.flow && !rd_flow_clr_i) |=> flags_q.flow); // R9

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_id_pkg::*;
#(
  parameter int EN_W = SRC_EN_W,
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  irq_flags_t      flags_q,
  input  logic [EN_W-1:0] en_q,
  input  logic            enh_q,
  output irq_src_e        src_o
);

  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;

  always_comb begin
    req          = '0;
    req[P_LSR]   = flags_q.lsr   & en_q[EN_LSR];
    req[P_RXTO]  = flags_q.rxto  & en_q[EN_RX];
    req[P_RXRDY] = flags_q.rxrdy & en_q[EN_RX];
    req[P_THR]   = flags_q.thr   & en_q[EN_THR];
    req[P_MSR]   = flags_q.msr   & en_q[EN_MSR];
    req[P_XOFF]  = flags_q.xoff  & en_q[EN_XOFF] & enh_q;
    req[P_FLOW]  = flags_q.flow  & en_q[EN_FLOW] & enh_q;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_grant
      if (i == 0) begin : g_top
        assign grant[i] = req[i];
      end else begin : g_rest
        assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    src_o = SRC_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) src_o = irq_src_e'(i + 1);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (src_o != SRC_NONE)); // R3
  AST_ENH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_q |-> (src_o != SRC_XOFF && src_o != SRC_FLOW)); // R6

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_id_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lsr_err_i,
  input  logic                rx_rdy_i,
  input  logic                rx_tmo_i,
  input  logic                thr_empty_set_i,
  input  logic                thr_write_i,
  input  logic                msr_chg_i,
  input  logic                xoff_det_i,
  input  logic                xon_det_i,
  input  logic                flow_chg_i,
  input  logic                isr_rd_i,
  input  logic [SRC_EN_W-1:0] src_en_i,
  input  logic                enh_en_i,
  input  logic                fifo_en_i,
  output logic [ISR_W-1:0]    isr_o,
  output logic                irq_o
);

  irq_flags_t          flags_q;
  logic [SRC_EN_W-1:0] en_q;
  logic                enh_q;
  logic                fifo_q;
  irq_src_e            src;
  logic                rd_thr_clr;
  logic                rd_flow_clr;

  assign rd_thr_clr  = isr_rd_i & (src == SRC_THR);
  assign rd_flow_clr = isr_rd_i & (src == SRC_FLOW);

  uart_irq_src_regs #(.EN_W(SRC_EN_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .lsr_err_i    (lsr_err_i),
    .rx_rdy_i     (rx_rdy_i),
    .rx_tmo_i     (rx_tmo_i),
    .thr_set_i    (thr_empty_set_i),
    .thr_wr_i     (thr_write_i),
    .msr_chg_i    (msr_chg_i),
    .xoff_det_i   (xoff_det_i),
    .xon_det_i    (xon_det_i),
    .flow_chg_i   (flow_chg_i),
    .rd_thr_clr_i (rd_thr_clr),
    .rd_flow_clr_i(rd_flow_clr),
    .src_en_i     (src_en_i),
    .enh_en_i     (enh_en_i),
    .fifo_en_i    (fifo_en_i),
    .flags_q      (flags_q),
    .en_q         (en_q),
    .enh_q        (enh_q),
    .fifo_q       (fifo_q)
  );

  uart_irq_prio #(.EN_W(SRC_EN_W), .NSRC(NUM_SRC)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags_q(flags_q),
    .en_q   (en_q),
    .enh_q  (enh_q),
    .src_o  (src)
  );

  assign isr_o = {{2{fifo_q}}, src_code(src)};
  assign irq_o = (src != SRC_NONE);

  // marks that one clock edge has passed since reset, for $past checks
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IRQ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o != isr_o[0]); // R4
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> isr_o[7:6] == {2{$past(fifo_en_i)}}); // R10
  AST_LSR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(lsr_err_i && src_en_i[EN_LSR])) |-> isr_o[5:0] == ID_LSR); // R3
  AST_THR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd_i && isr_o[5:0] == ID_THR && !thr_empty_set_i) |=> isr_o[5:0] != ID_THR); // R8

endmodule

// File: tb/uart_irq_id_tb_top.sv
module uart_irq_id_tb_top;

  logic       clk;
  logic       rst_n;
  logic       lsr_err, rx_rdy, rx_tmo, thr_set, thr_wr, msr_chg;
  logic       xoff_det, xon_det, flow_chg, isr_rd, enh_en, fifo_en;
  logic [5:0] src_en;
  logic [7:0] isr;
  logic       irq;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  uart_irq_id dut_i (
    .clk(clk), .rst_n(rst_n), .lsr_err_i(lsr_err), .rx_rdy_i(rx_rdy),
    .rx_tmo_i(rx_tmo), .thr_empty_set_i(thr_set), .thr_write_i(thr_wr),
    .msr_chg_i(msr_chg), .xoff_det_i(xoff_det), .xon_det_i(xon_det),
    .flow_chg_i(flow_chg), .isr_rd_i(isr_rd), .src_en_i(src_en),
    .enh_en_i(enh_en), .fifo_en_i(fifo_en), .isr_o(isr), .irq_o(irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // behavioural reference state
  bit       m_lsr, m_rdy, m_tmo, m_thr, m_msr, m_xoff, m_flow, m_enh, m_fifo;
  bit [5:0] m_en;

  function automatic logic [7:0] model_isr();
    logic [5:0] id;
    if      (m_lsr && m_en[2])            id = 6'h06;
    else if (m_tmo && m_en[0])            id = 6'h0C;
    else if (m_rdy && m_en[0])            id = 6'h04;
    else if (m_thr && m_en[1])            id = 6'h02;
    else if (m_msr && m_en[3])            id = 6'h00;
    else if (m_enh && m_xoff && m_en[4])  id = 6'h10;
    else if (m_enh && m_flow && m_en[5])  id = 6'h20;
    else                                  id = 6'h01;
    return {m_fifo, m_fifo, id};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_lsr, m_rdy, m_tmo, m_thr, m_msr, m_xoff, m_flow, m_enh, m_fifo} = '0;
      m_en = '0;
    end else begin
      logic [7:0] now;
      now    = model_isr();
      m_thr  = thr_set  || (m_thr  && !(thr_wr || (isr_rd && now[5:0] == 6'h02)));
      m_xoff = xoff_det || (m_xoff && !xon_det);
      m_flow = flow_chg || (m_flow && !(isr_rd && now[5:0] == 6'h20));
      m_lsr  = lsr_err; m_rdy = rx_rdy; m_tmo = rx_tmo; m_msr = msr_chg;
      m_en   = src_en;  m_enh = enh_en; m_fifo = fifo_en;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: isr actual %02h expected %02h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_irq(input string req);
    logic [7:0] e;
    e = model_isr();
    chk(req, isr, e);
    n_checks++;
    if (irq !== (e[0] == 1'b0)) begin
      n_fails++;
      $display("FAIL %s: irq actual %0b expected %0b", req, irq, e[0] == 1'b0);
    end
  endtask

  // one clock; outputs compared with the model at the falling edge
  task automatic step();
    @(negedge clk);
    chk_irq(cur_req);
  endtask

  task automatic idle_inputs();
    {lsr_err, rx_rdy, rx_tmo, thr_set, thr_wr, msr_chg} = '0;
    {xoff_det, xon_det, flow_chg, isr_rd} = '0;
  endtask

  task automatic pulse_clear();
    {thr_set, thr_wr, xoff_det, xon_det, flow_chg, isr_rd} = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    src_en = '0; enh_en = 0; fifo_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", isr, 8'h01);
    rst_n = 1;
    step(); step();
    chk("R1", isr, 8'h01);

    // R2: each source alone
    cur_req = "R2";
    src_en = 6'h3F; enh_en = 1;
    step();
    lsr_err = 1; step(); chk("R2", isr, 8'h06); lsr_err = 0;
    rx_tmo  = 1; step(); chk("R2", isr, 8'h0C); rx_tmo = 0;
    rx_rdy  = 1; step(); chk("R2", isr, 8'h04); rx_rdy = 0;
    msr_chg = 1; step(); chk("R2", isr, 8'h00); msr_chg = 0;
    thr_set = 1; step(); chk("R2", isr, 8'h02); thr_set = 0;
    thr_wr  = 1; step(); chk("R8", isr, 8'h01); thr_wr = 0;
    xoff_det = 1; step(); chk("R2", isr, 8'h10); xoff_det = 0;
    xon_det  = 1; step(); chk("R7", isr, 8'h01); xon_det = 0;
    flow_chg = 1; step(); chk("R2", isr, 8'h20); flow_chg = 0;
    isr_rd   = 1; step(); chk("R9", isr, 8'h01); isr_rd = 0;

    // R3: all pending, peel from the top
    cur_req = "R3";
    xoff_det = 1; flow_chg = 1; thr_set = 1; step(); pulse_clear();
    lsr_err = 1; rx_tmo = 1; rx_rdy = 1; msr_chg = 1;
    step(); chk("R3", isr, 8'h06);
    lsr_err = 0; step(); chk("R3", isr, 8'h0C);
    rx_tmo  = 0; step(); chk("R3", isr, 8'h04);
    rx_rdy  = 0; step(); chk("R3", isr, 8'h02);
    // R8: read while THR reported clears it
    isr_rd = 1; step(); isr_rd = 0; chk("R8", isr, 8'h00);
    msr_chg = 0; step(); chk("R3", isr, 8'h10);
    // R9: read while Xoff reported does not clear flow
    isr_rd = 1; step(); isr_rd = 0; chk("R9", isr, 8'h10);
    xon_det = 1; step(); xon_det = 0; chk("R7", isr, 8'h20);

    // R4: irq mirrors bit 0
    cur_req = "R4";
    step(); chk("R4", {7'h0, irq}, 8'h01);
    isr_rd = 1; step(); isr_rd = 0; chk("R4", {7'h0, irq}, 8'h00);

    // R5: enables mask sources
    cur_req = "R5";
    src_en = 6'h00; lsr_err = 1; rx_rdy = 1; msr_chg = 1; thr_set = 1;
    step(); thr_set = 0; chk("R5", isr, 8'h01);
    src_en = 6'h08; step(); chk("R5", isr, 8'h00);
    src_en = 6'h0A; step(); chk("R5", isr, 8'h02);
    src_en = 6'h0B; step(); chk("R5", isr, 8'h04);
    src_en = 6'h0F; step(); chk("R5", isr, 8'h06);
    lsr_err = 0; rx_rdy = 0; msr_chg = 0; thr_wr = 1; step(); thr_wr = 0;
    src_en = 6'h3F;

    // R6: enhanced enable gates Xoff and flow
    cur_req = "R6";
    enh_en = 0; xoff_det = 1; flow_chg = 1; step(); pulse_clear();
    chk("R6", isr, 8'h01);
    isr_rd = 1; step(); isr_rd = 0; chk("R6", isr, 8'h01);
    enh_en = 1; step(); chk("R6", isr, 8'h10);

    // R7: hold many cycles, same-cycle detect and Xon keeps it set
    cur_req = "R7";
    repeat (20) step();
    chk("R7", isr, 8'h10);
    xoff_det = 1; xon_det = 1; step(); pulse_clear(); chk("R7", isr, 8'h10);
    xon_det = 1; step(); xon_det = 0; chk("R7", isr, 8'h20);
    isr_rd = 1; step(); isr_rd = 0; chk("R9", isr, 8'h01);

    // R8: read while higher source reported; set wins over clear
    cur_req = "R8";
    thr_set = 1; lsr_err = 1; step(); thr_set = 0;
    isr_rd = 1; step(); isr_rd = 0; chk("R8", isr, 8'h06);
    lsr_err = 0; step(); chk("R8", isr, 8'h02);
    isr_rd = 1; thr_set = 1; step(); pulse_clear(); chk("R8", isr, 8'h02);
    thr_wr = 1; thr_set = 1; step(); pulse_clear(); chk("R8", isr, 8'h02);
    thr_wr = 1; step(); thr_wr = 0; chk("R8", isr, 8'h01);

    // R10: FIFO bits
    cur_req = "R10";
    fifo_en = 1; step(); chk("R10", isr, 8'hC1);
    rx_rdy = 1; step(); chk("R10", isr, 8'hC4);
    fifo_en = 0; rx_rdy = 0; step(); chk("R10", isr, 8'h01);

    // R11: no output change before the sampling edge
    cur_req = "R11";
    lsr_err = 1; #1; chk("R11", isr, 8'h01);
    step(); chk("R11", isr, 8'h06);
    lsr_err = 0; #1; chk("R11", isr, 8'h06);
    step(); chk("R11", isr, 8'h01);

    // mixed random traffic against the model
    cur_req = "R3";
    void'($urandom(32'h1D5));
    for (int i = 0; i < 3000; i++) begin
      lsr_err  = ($urandom % 8) == 0;
      rx_rdy   = ($urandom % 3) == 0;
      rx_tmo   = ($urandom % 6) == 0;
      msr_chg  = ($urandom % 4) == 0;
      thr_set  = ($urandom % 5) == 0;
      thr_wr   = ($urandom % 7) == 0;
      xoff_det = ($urandom % 9) == 0;
      xon_det  = ($urandom % 9) == 0;
      flow_chg = ($urandom % 6) == 0;
      isr_rd   = ($urandom % 2) == 0;
      if (($urandom % 16) == 0) src_en = 6'($urandom);
      if (($urandom % 32) == 0) enh_en = ~enh_en;
      if (($urandom % 32) == 0) fifo_en = ~fifo_en;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule